// File: doc/BRIEF.md
# Clock-Oversampled SPI Target Front End with Pause Control

This block is the serial edge of a memory-style SPI target. It watches the four bus pins (serial clock, active-low select, serial input and an active-low pause request) through a synchroniser running on a faster system clock. It detects clock edges in that domain and shifts bytes in and out most significant bit first. A downstream command decoder receives each completed byte as a one-cycle strobe with its position in the current selection. The decoder hands back response bytes that appear on the serial output one bit per falling clock edge.

The pause input stops a transfer without deselecting the target. Entry into and exit from pause take effect only while the serial clock is low. A request that changes while the clock is high waits for the next low phase. While paused the output floats and clock or data activity is ignored, so the transfer resumes at the bit where it stopped. Releasing the select line during a pause clears all serial state.

Flow rules. The receive stream has no back-pressure because the serial master cannot be stalled: `rx_valid` is high for exactly one cycle and the decoder must take `rx_data` then. The transmit stream is valid/ready. The decoder raises `tx_valid` with `tx_data` and holds both until `tx_ready` pulses. `tx_ready` pulses only on the falling clock edge that opens a byte slot. If `tx_valid` is low at that edge, the slot stays empty and the output floats for the whole byte.

Top module: `spi_hold_target`

## Requirements
- R1: While the select line is high, `so_oe` is low, no `rx_valid` is produced, and the bit and byte counters return to zero.
- R2: The serial input is sampled on each rising clock edge, most significant bit first. After the eighth sampled bit, `rx_valid` pulses for one cycle with the assembled byte on `rx_data`.
- R3: Transfers behave the same whether the clock idles low (mode 0) or high (mode 3) when the select line falls.
- R4: `rx_idx` gives the position of the received byte within the current selection. It starts at 0 and increments per byte, and a new selection restarts it at 0.
- R5: A pause request (`hold_n` low) seen while the clock is low enters pause at once. If the clock is high, entry waits until the clock next goes low.
- R6: A release (`hold_n` high) seen while the clock is low leaves pause at once. If the clock is high, exit waits until the clock next goes low.
- R7: While paused, `so_oe` is low and clock edges and serial input are ignored. After release the byte continues from the paused bit for both directions.
- R8: Releasing the select line while paused clears the pause and all partial-byte state. The next selection starts a fresh byte at index 0.
- R9: On the falling edge that opens a byte slot with `tx_valid` high, `tx_ready` pulses. That byte then drives `so_data` from bit 7 to bit 0, one bit per falling edge, with `so_oe` high.
- R10: If `tx_valid` is low when a byte slot opens, `so_oe` stays low for that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low target select |
| si | input | 1 | Serial data into the target |
| hold_n | input | 1 | Active-low pause request |
| so_data | output | 1 | Serial data out of the target |
| so_oe | output | 1 | Output enable for `so_data`; low means high impedance |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_idx | output | 16 | Index of the received byte within the selection |
| tx_valid | input | 1 | Response byte offered by the decoder |
| tx_ready | output | 1 | Response byte accepted this cycle |
| tx_data | input | 8 | Response byte |

## Verification
The assertions check the cycle-level rules on every cycle: pause state cannot change while the clock level is high, a paused target produces neither received bytes nor output enable, and a deselected target floats its output and holds no pause. They also check that the receive strobe lasts one cycle and that an accepted response byte turns the output on. Only the directed scenarios can show byte values and bit order in both clock modes, resumption at the exact paused bit, the deferred entry and exit seen at the output enable, and a clean restart after deselection during pause.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Pin bundle as seen by the synchroniser
  typedef struct packed {
    logic sck;
    logic cs_n;
    logic si;
    logic hold_n;
  } pin_set_t;

  localparam int PIN_W = $bits(pin_set_t);

  // Idle values: clock low, deselected, data low, no pause
  localparam pin_set_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, si: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic sck_lvl,
  input  logic hold_lvl,
  output logic held
);

  // Pause state may only change during the clock-low phase; a request
  // arriving while the clock is high is picked up on the next low phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held <= 1'b0;
    else if (!cs_act)  held <= 1'b0;
    else if (!sck_lvl) held <= ~hold_lvl;
  end

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int BYTE_W = 8,
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rise_evt,
  input  logic              si_lvl,
  output logic              at_boundary,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic [IDX_W-1:0]  rx_idx
);

  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  idx_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_byte;

  assign next_byte   = {shreg[BYTE_W-2:0], si_lvl};
  assign at_boundary = (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      idx_cnt  <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_idx   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        idx_cnt <= '0;
        shreg   <= '0;
      end else if (rise_evt) begin
        shreg <= next_byte;
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          rx_valid <= 1'b1;
          rx_data  <= next_byte;
          rx_idx   <= idx_cnt;
          idx_cnt  <= idx_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              held,
  input  logic              fall_evt,
  input  logic              at_boundary,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              so_data,
  output logic              so_oe
);

  logic [BYTE_W-1:0] shreg;
  logic              pending;

  assign tx_ready = fall_evt & at_boundary & tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      pending <= 1'b0;
      so_data <= 1'b0;
    end else if (!cs_act) begin
      shreg   <= '0;
      pending <= 1'b0;
      so_data <= 1'b0;
    end else if (fall_evt) begin
      if (at_boundary) begin
        pending <= tx_valid;
        if (tx_valid) begin
          so_data <= tx_data[BYTE_W-1];
          shreg   <= {tx_data[BYTE_W-2:0], 1'b0};
        end
      end else begin
        so_data <= shreg[BYTE_W-1];
        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // Output enable follows select, pending slot and pause one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) so_oe <= 1'b0;
    else        so_oe <= cs_act & pending & ~held;
  end

endmodule

// File: rtl/spi_hold_target.sv
module spi_hold_target
  import spi_hold_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so_data,
  output logic              so_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic [IDX_W-1:0]  rx_idx,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data
);

  pin_set_t raw_pins;
  pin_set_t syn_pins;
  logic [PIN_W-1:0] syn_vec;

  assign raw_pins.sck    = sck;
  assign raw_pins.cs_n   = cs_n;
  assign raw_pins.si     = si;
  assign raw_pins.hold_n = hold_n;

  spi_pin_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_pins),
    .q    (syn_vec)
  );

  assign syn_pins = pin_set_t'(syn_vec);

  logic cs_act;
  logic sck_lvl;
  logic sck_prev;
  logic held;
  logic rise_evt;
  logic fall_evt;
  logic at_boundary;

  assign cs_act  = ~syn_pins.cs_n;
  assign sck_lvl = syn_pins.sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_lvl;
  end

  spi_hold_ctl u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .sck_lvl (sck_lvl),
    .hold_lvl(syn_pins.hold_n),
    .held    (held)
  );

  assign rise_evt = cs_act & ~held &  sck_lvl & ~sck_prev;
  assign fall_evt = cs_act & ~held & ~sck_lvl &  sck_prev;

  spi_rx_shift #(
    .BYTE_W(BYTE_W),
    .IDX_W (IDX_W)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .rise_evt   (rise_evt),
    .si_lvl     (syn_pins.si),
    .at_boundary(at_boundary),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_idx     (rx_idx)
  );

  spi_tx_shift #(
    .BYTE_W(BYTE_W)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .held       (held),
    .fall_evt   (fall_evt),
    .at_boundary(at_boundary),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .so_data    (so_data),
    .so_oe      (so_oe)
  );

endmodule

// File: rtl/spi_hold_target_chk.sv
module spi_hold_target_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic sck_lvl,
  input logic held,
  input logic so_oe,
  input logic rx_valid,
  input logic tx_ready
);

  assert_idle_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_oe);

  assert_rx_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_defer_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sck_lvl && !held) |=> !held);

  assert_defer_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sck_lvl && held) |=> held);

  assert_hold_blocks_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> !rx_valid);

  assert_hold_floats_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> !so_oe);

  assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !held);

  assert_accept_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready ##1 (cs_act && !held)) |=> so_oe);

endmodule

bind spi_hold_target spi_hold_target_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_act  (cs_act),
  .sck_lvl (sck_lvl),
  .held    (held),
  .so_oe   (so_oe),
  .rx_valid(rx_valid),
  .tx_ready(tx_ready)
);

// File: tb/spi_hold_target_test.sv
`timescale 1ns/1ps
module spi_hold_target_test;

  localparam int H = 8;  // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        si = 1'b0;
  logic        hold_n = 1'b1;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        so_data, so_oe, rx_valid, tx_ready;
  logic [7:0]  rx_data;
  logic [15:0] rx_idx;

  int total = 0;
  int bad = 0;
  int rx_n = 0;
  logic [7:0]  rx_log [16];
  logic [15:0] idx_log [16];

  always #2 clk = ~clk;

  spi_hold_target uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so_data(so_data), .so_oe(so_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_idx(rx_idx), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  always @(negedge clk) begin
    if (rx_valid && rx_n < 16) begin
      rx_log[rx_n]  = rx_data;
      idx_log[rx_n] = rx_idx;
      rx_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic so_b, output logic oe_b);
    sck = 1'b0;
    si = b;
    wait_half();
    so_b = so_data;
    oe_b = so_oe;
    sck = 1'b1;
    wait_half();
  endtask

  task automatic bits_io(input logic [7:0] d, input int hi, input int lo,
                         inout logic [7:0] got, inout int oe_cnt);
    logic sb, ob;
    for (int i = hi; i >= lo; i--) begin
      bit_io(d[i], sb, ob);
      got[i] = sb;
      oe_cnt += int'(ob);
    end
  endtask

  task automatic begin_sel(input logic idle_high);
    rx_n = 0;
    sck = idle_high;
    hold_n = 1'b1;
    wait_half();
    cs_n = 1'b0;
    wait_half();
  endtask

  task automatic end_sel(input logic idle_high);
    if (!idle_high) begin
      sck = 1'b0;
      wait_half();
    end
    cs_n = 1'b1;
    wait_half();
  endtask

  task automatic feed_tx(input logic [7:0] d);
    tx_data = d;
    tx_valid = 1'b1;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1", "so_oe after reset", int'(so_oe), 0);
    chk("R1", "rx_valid after reset", int'(rx_valid), 0);
  endtask

  task automatic test_mode0();
    logic [7:0] g0 = '0, g1 = '0;
    int oe0 = 0, oe1 = 0;
    begin_sel(1'b0);
    bits_io(8'hA5, 7, 0, g0, oe0);
    chk("R10", "oe bits with no response byte", oe0, 0);
    fork feed_tx(8'h96); join_none
    bits_io(8'h3C, 7, 0, g1, oe1);
    chk("R9", "mode0 response byte", int'(g1), 'h96);
    chk("R9", "mode0 oe bits", oe1, 8);
    sck = 1'b0;
    wait_half();
    chk("R10", "empty slot floats", int'(so_oe), 0);
    cs_n = 1'b1;
    wait_half();
    chk("R1", "so_oe when deselected", int'(so_oe), 0);
    chk("R2", "mode0 byte count", rx_n, 2);
    chk("R2", "mode0 byte 0", int'(rx_log[0]), 'hA5);
    chk("R3", "mode0 byte 1", int'(rx_log[1]), 'h3C);
    chk("R4", "mode0 index 0", int'(idx_log[0]), 0);
    chk("R4", "mode0 index 1", int'(idx_log[1]), 1);
  endtask

  task automatic test_mode3();
    logic [7:0] g = '0;
    int oe = 0;
    begin_sel(1'b1);
    fork feed_tx(8'hC3); join_none
    bits_io(8'h5A, 7, 0, g, oe);
    end_sel(1'b1);
    sck = 1'b0;
    wait_half();
    chk("R3", "mode3 response byte", int'(g), 'hC3);
    chk("R9", "mode3 oe bits", oe, 8);
    chk("R3", "mode3 byte count", rx_n, 1);
    chk("R3", "mode3 received byte", int'(rx_log[0]), 'h5A);
    chk("R4", "index restarts at new selection", int'(idx_log[0]), 0);
  endtask

  task automatic test_hold_low();
    logic [7:0] g0 = '0, g1 = '0;
    int oe0 = 0, oe1 = 0;
    begin_sel(1'b0);
    bits_io(8'h11, 7, 0, g0, oe0);
    fork feed_tx(8'hE7); join_none
    bits_io(8'h4D, 7, 4, g1, oe1);
    sck = 1'b0;
    wait_half();
    hold_n = 1'b0;
    wait_half();
    chk("R5", "pause entered while clock low", int'(so_oe), 0);
    repeat (3) begin
      si = ~si;
      sck = 1'b1;
      wait_half();
      sck = 1'b0;
      wait_half();
    end
    chk("R7", "no byte during pause", rx_n, 1);
    hold_n = 1'b1;
    wait_half();
    chk("R6", "pause left while clock low", int'(so_oe), 1);
    bits_io(8'h4D, 3, 0, g1, oe1);
    end_sel(1'b0);
    chk("R7", "byte across pause", int'(rx_log[1]), 'h4D);
    chk("R7", "response across pause", int'(g1), 'hE7);
    chk("R7", "oe bits across pause", oe1, 8);
  endtask

  task automatic test_hold_high();
    logic [7:0] g0 = '0, g1 = '0;
    int oe0 = 0, oe1 = 0;
    begin_sel(1'b0);
    bits_io(8'h22, 7, 0, g0, oe0);
    fork feed_tx(8'h5E); join_none
    bits_io(8'hB4, 7, 5, g1, oe1);
    hold_n = 1'b0;
    wait_half();
    chk("R5", "entry deferred while clock high", int'(so_oe), 1);
    sck = 1'b0;
    wait_half();
    chk("R5", "entry at next low phase", int'(so_oe), 0);
    sck = 1'b1;
    si = 1'b1;
    wait_half();
    hold_n = 1'b1;
    wait_half();
    chk("R6", "exit deferred while clock high", int'(so_oe), 0);
    sck = 1'b0;
    wait_half();
    chk("R6", "exit at next low phase", int'(so_oe), 1);
    bits_io(8'hB4, 4, 0, g1, oe1);
    end_sel(1'b0);
    chk("R7", "byte across deferred pause", int'(rx_log[1]), 'hB4);
    chk("R7", "response across deferred pause", int'(g1), 'h5E);
  endtask

  task automatic test_cs_in_hold();
    logic [7:0] g = '0;
    int oe = 0;
    begin_sel(1'b0);
    bits_io(8'hA0, 7, 5, g, oe);
    sck = 1'b0;
    wait_half();
    hold_n = 1'b0;
    wait_half();
    cs_n = 1'b1;
    wait_half();
    chk("R8", "so_oe deselected in pause", int'(so_oe), 0);
    hold_n = 1'b1;
    wait_half();
    cs_n = 1'b0;
    wait_half();
    bits_io(8'h6B, 7, 0, g, oe);
    end_sel(1'b0);
    chk("R8", "byte count after restart", rx_n, 1);
    chk("R8", "fresh byte after restart", int'(rx_log[0]), 'h6B);
    chk("R8", "index after restart", int'(idx_log[0]), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    test_reset();
    test_mode0();
    test_mode3();
    test_hold_low();
    test_hold_high();
    test_cs_in_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule